// File: doc/BRIEF.md
# Serial Transmit Register Block

This block is a word-addressed peripheral that turns bytes written by software into an asynchronous serial stream. Bytes written to the transmit-data register go into a byte FIFO. A shifter empties that FIFO onto the `txd` line in 8N1 frames, at a bit rate set by a fractional baud accumulator. A single receive holding register captures bytes that arrive on a valid/ready input. Four interrupt outputs report TX watermark, RX watermark, TX empty and RX overflow. Each is gated by an enable register. Software can set interrupts through a test register and clears them by writing 1s.

Register accesses are 32-bit words in a 0x400-byte window. A request is presented for one cycle on `bus_valid`. A read answers one cycle later on `rsp_valid`/`rsp_rdata`. The register port has no back-pressure. The receive input follows valid/ready rules: a byte is taken in a cycle where both `rx_valid` and `rx_ready` are high. `rx_ready` is the receive-enable control bit, so the sender must hold the byte until the receiver is enabled.

Register map (byte offsets): 0x00 interrupt state, 0x04 interrupt enable, 0x08 interrupt test, 0x0C control, 0x10 status, 0x14 receive data, 0x18 transmit data, 0x1C FIFO control, 0x20 FIFO status. Interrupt bits, in every interrupt register: 0 TX watermark, 1 RX watermark, 2 TX empty, 3 RX overflow.

Top module: `sertx_top`

## Requirements
- R1: Each interrupt output (`irq_tx_wm`, `irq_rx_wm`, `irq_tx_empty`, `irq_rx_ovf`) is high exactly when its interrupt-state bit and its interrupt-enable bit are both set (bits 0..3 as listed above).
- R2: A write to interrupt state (0x00) clears each bit written as 1. A write to interrupt test (0x08) ORs bits 3:0 of the written value into interrupt state.
- R3: After reset, status (0x10) reads 0x3C and every other register, the TX level, all interrupt outputs and `rx_ready` are 0. `txd` is 1.
- R4: A write to transmit data (0x18) pushes bits 7:0 into a FIFO of DEPTH (32) bytes. A push into a full FIFO is dropped and the level stays the same. FIFO status (0x20) bits 5:0 read the level. Status bit 0 (TX full) is set exactly when the level equals DEPTH.
- R5: A push that leaves the level at or above the threshold in FIFO control bits 12:8 sets interrupt-state bit 0. A byte leaving the FIFO that takes the level below the threshold clears that bit.
- R6: When the last byte leaves the FIFO, interrupt-state bit 2 (TX empty) is set and bit 0 is cleared. Status bit 2 (TX empty) reads 1 whenever the level is 0. Status bit 3 (TX idle) reads 1 once the level is 0 and the last frame has finished.
- R7: A write to FIFO control with bit 1 set empties the TX FIFO at once, and the flushed bytes are never sent.
- R8: Bytes go out in FIFO order, each as a start bit (0), eight data bits LSB first, then a stop bit (1). Every bit lasts one baud period. Frames may follow each other with no gap.
- R9: With control bit 0 (TX enable) clear, `txd` holds its value and the FIFO level does not change.
- R10: `rx_ready` equals control bit 1 (RX enable). A byte taken on the receive input is stored and clears status bits 4 (RX idle) and 5 (RX empty). Status bit 1 (RX full) reads as the inverse of bit 5. A read of receive data (0x14) returns the stored byte and sets bits 4 and 5.
- R11: A read returns data on `rsp_valid` in the following cycle. Write-only registers (0x08, 0x18), unmapped offsets and accesses whose address bits 1:0 are not zero read 0. A misaligned write changes nothing.
- R12: The baud period is set by control bits 31:16. That value is added to a 16-bit accumulator every clock while TX is enabled, and each carry out ends one bit period. An increment of 0x4000 gives 4 clocks per bit and 0x2000 gives 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receiver accepts bytes (RX enable) |
| rx_data | input | 8 | Received byte |
| txd | output | 1 | Serial transmit line, idle high |
| irq_tx_wm | output | 1 | TX watermark interrupt |
| irq_rx_wm | output | 1 | RX watermark interrupt |
| irq_tx_empty | output | 1 | TX empty interrupt |
| irq_rx_ovf | output | 1 | RX overflow interrupt |

## Verification
A register write takes effect at the clock edge that samples it. Interrupt state, level, status and interrupt outputs therefore show the new value one cycle after the request, and the bench samples them on the following falling edge. A read answers on the edge after the request, so the bench takes `rsp_rdata` on the falling edge that follows it. A FIFO byte is popped, and its start bit driven, on the first baud carry after TX is enabled or after the previous stop bit. The bench does not count cycles for this. It waits for the falling start edge, moves half a bit period in, and samples once per period, which checks the frame no matter which tick phase the frame starts on.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int ADDR_W = 10;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int NINTR  = 4;

  localparam logic [ADDR_W-1:0] OFF_ISTATE = 10'h000;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 10'h004;
  localparam logic [ADDR_W-1:0] OFF_ITEST  = 10'h008;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 10'h00C;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 10'h010;
  localparam logic [ADDR_W-1:0] OFF_RXD    = 10'h014;
  localparam logic [ADDR_W-1:0] OFF_TXD    = 10'h018;
  localparam logic [ADDR_W-1:0] OFF_FCTRL  = 10'h01C;
  localparam logic [ADDR_W-1:0] OFF_FSTAT  = 10'h020;

  // interrupt bit positions
  localparam int IB_TXWM    = 0;
  localparam int IB_RXWM    = 1;
  localparam int IB_TXEMPTY = 2;
  localparam int IB_RXOVF   = 3;

  // control register fields
  localparam int CT_TXEN    = 0;
  localparam int CT_RXEN    = 1;
  localparam int CT_INC_LSB = 16;
  localparam int INC_W      = 16;

  // FIFO control fields
  localparam int FC_TXRST   = 1;
  localparam int FC_THR_LSB = 8;

  // status bit positions
  localparam int ST_TXFULL  = 0;
  localparam int ST_RXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_TXIDLE  = 3;
  localparam int ST_RXIDLE  = 4;
  localparam int ST_RXEMPTY = 5;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [LVL_W-1:0] level
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             push, pop;

  assign in_ready  = (level != LVL_W'(DEPTH));
  assign out_valid = (level != '0);
  assign push      = in_valid && in_ready && !flush;
  assign pop       = out_valid && out_ready && !flush;
  assign out_data  = mem[rptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic             tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc} + {1'b0, inc};
  assign tick = en && sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (en)  acc <= sum[ACC_W-1:0];
    else          acc <= '0;
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int DW = 8,
  localparam int FRAME = DW + 2,
  localparam int CNT_W = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          txd,
  output logic          busy
);
  logic [FRAME-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last     = (cnt == CNT_W'(FRAME - 1));
  assign in_ready = tick && (!busy || last);
  assign txd      = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (tick) begin
      if (!busy || last) begin
        if (in_valid) begin
          shreg <= {1'b1, in_data, 1'b0};
          cnt   <= '0;
          busy  <= 1'b1;
        end else begin
          shreg <= '1;
          cnt   <= '0;
          busy  <= 1'b0;
        end
      end else begin
        shreg <= {1'b1, shreg[FRAME-1:1]};
        cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              rsp_valid,
  output logic [REG_W-1:0]  rsp_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              txd,
  output logic              irq_tx_wm,
  output logic              irq_rx_wm,
  output logic              irq_tx_empty,
  output logic              irq_rx_ovf
);
  localparam int TH_W  = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  // ---------------- register decode ----------------
  logic aligned, wr_en, rd_en;
  logic wr_istate, wr_ien, wr_itest, wr_ctrl, wr_txd, wr_fctrl, rd_rxd;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign wr_en     = bus_valid && bus_write && aligned;
  assign rd_en     = bus_valid && !bus_write && aligned;
  assign wr_istate = wr_en && (bus_addr == OFF_ISTATE);
  assign wr_ien    = wr_en && (bus_addr == OFF_IEN);
  assign wr_itest  = wr_en && (bus_addr == OFF_ITEST);
  assign wr_ctrl   = wr_en && (bus_addr == OFF_CTRL);
  assign wr_txd    = wr_en && (bus_addr == OFF_TXD);
  assign wr_fctrl  = wr_en && (bus_addr == OFF_FCTRL);
  assign rd_rxd    = rd_en && (bus_addr == OFF_RXD);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // ---------------- control state ----------------
  logic [NINTR-1:0]  int_state, int_en, int_state_nxt;
  logic              tx_en, rx_en;
  logic [INC_W-1:0]  baud_inc;
  logic [TH_W-1:0]   thr;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_idle, rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en   <= '0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      baud_inc <= '0;
      thr      <= '0;
    end else begin
      if (wr_ien) int_en <= bus_wdata[NINTR-1:0];
      if (wr_ctrl) begin
        tx_en    <= bus_wdata[CT_TXEN];
        rx_en    <= bus_wdata[CT_RXEN];
        baud_inc <= bus_wdata[CT_INC_LSB +: INC_W];
      end
      if (wr_fctrl) thr <= bus_wdata[FC_THR_LSB +: TH_W];
    end
  end

  // ---------------- transmit datapath ----------------
  logic              push_req, push_ok, flush, pop;
  logic              fifo_in_ready, fifo_out_valid, shift_ready, shift_busy;
  logic [BYTE_W-1:0] fifo_head;
  logic [LVL_W-1:0]  fifo_lvl;
  logic              baud_tick;

  assign push_req = wr_txd;
  assign flush    = wr_fctrl && bus_wdata[FC_TXRST];
  assign push_ok  = push_req && fifo_in_ready && !flush;
  assign pop      = fifo_out_valid && shift_ready && !flush;

  sertx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (push_req),
    .in_ready  (fifo_in_ready),
    .in_data   (bus_wdata[BYTE_W-1:0]),
    .out_valid (fifo_out_valid),
    .out_ready (shift_ready),
    .out_data  (fifo_head),
    .level     (fifo_lvl)
  );

  sertx_baud #(.ACC_W(INC_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tx_en),
    .inc   (baud_inc),
    .tick  (baud_tick)
  );

  sertx_shifter #(.DW(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .in_valid (fifo_out_valid),
    .in_ready (shift_ready),
    .in_data  (fifo_head),
    .txd      (txd),
    .busy     (shift_busy)
  );

  // ---------------- interrupt state ----------------
  logic [LVL_W:0]   lvl_calc, thr_ext;
  logic             drained;
  logic [NINTR-1:0] hw_set, hw_clr, sw_clr, sw_set;

  assign thr_ext = (LVL_W + 1)'(thr);

  always_comb begin
    if (flush) lvl_calc = '0;
    else       lvl_calc = {1'b0, fifo_lvl} + {{LVL_W{1'b0}}, push_ok}
                          - {{LVL_W{1'b0}}, pop};
  end

  assign drained = pop && (lvl_calc == '0);

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    hw_set[IB_TXWM]    = push_ok && (lvl_calc >= thr_ext);
    hw_clr[IB_TXWM]    = pop && ((lvl_calc < thr_ext) || drained);
    hw_set[IB_TXEMPTY] = drained;
  end

  assign sw_clr = wr_istate ? bus_wdata[NINTR-1:0] : '0;
  assign sw_set = wr_itest  ? bus_wdata[NINTR-1:0] : '0;
  assign int_state_nxt = (int_state & ~sw_clr & ~hw_clr) | sw_set | hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_state <= '0;
    else        int_state <= int_state_nxt;
  end

  assign irq_tx_wm    = int_state[IB_TXWM]    & int_en[IB_TXWM];
  assign irq_rx_wm    = int_state[IB_RXWM]    & int_en[IB_RXWM];
  assign irq_tx_empty = int_state[IB_TXEMPTY] & int_en[IB_TXEMPTY];
  assign irq_rx_ovf   = int_state[IB_RXOVF]   & int_en[IB_RXOVF];

  // ---------------- receive holding register ----------------
  logic rx_take;
  assign rx_ready = rx_en;
  assign rx_take  = rx_valid && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte  <= '0;
      rx_idle  <= 1'b1;
      rx_empty <= 1'b1;
    end else if (rx_take) begin
      rx_byte  <= rx_data;
      rx_idle  <= 1'b0;
      rx_empty <= 1'b0;
    end else if (rd_rxd) begin
      rx_idle  <= 1'b1;
      rx_empty <= 1'b1;
    end
  end

  // ---------------- read path ----------------
  logic [REG_W-1:0] status_word, rd_mux;

  always_comb begin
    status_word = '0;
    status_word[ST_TXFULL]  = (fifo_lvl == LVL_W'(DEPTH));
    status_word[ST_RXFULL]  = !rx_empty;
    status_word[ST_TXEMPTY] = (fifo_lvl == '0);
    status_word[ST_TXIDLE]  = (fifo_lvl == '0) && !shift_busy;
    status_word[ST_RXIDLE]  = rx_idle;
    status_word[ST_RXEMPTY] = rx_empty;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_ISTATE: rd_mux[NINTR-1:0] = int_state;
      OFF_IEN:    rd_mux[NINTR-1:0] = int_en;
      OFF_CTRL: begin
        rd_mux[CT_TXEN] = tx_en;
        rd_mux[CT_RXEN] = rx_en;
        rd_mux[CT_INC_LSB +: INC_W] = baud_inc;
      end
      OFF_STAT:   rd_mux = status_word;
      OFF_RXD:    rd_mux[BYTE_W-1:0] = rx_byte;
      OFF_FCTRL:  rd_mux[FC_THR_LSB +: TH_W] = thr;
      OFF_FSTAT:  rd_mux[LVL_W-1:0] = fifo_lvl;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid && !bus_write;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_req,
  input logic             push_ok,
  input logic             pop,
  input logic             flush,
  input logic [LVL_W-1:0] fifo_lvl,
  input logic [3:0]       int_state,
  input logic             shift_busy,
  input logic             txd,
  input logic             tx_en,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             rsp_valid
);
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_lvl <= LVL_W'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_lvl == LVL_W'(DEPTH) && push_req && !pop && !flush) |=> $stable(fifo_lvl));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifo_lvl == '0));

  assert_drain_sets_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_ok && !flush && fifo_lvl == LVL_W'(1)) |=> (int_state[2] && !int_state[0]));

  assert_start_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_busy) |-> !txd);

  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> ($stable(txd) && $stable(shift_busy)));

  assert_read_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);
endmodule

bind sertx_top sertx_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_req   (push_req),
  .push_ok    (push_ok),
  .pop        (pop),
  .flush      (flush),
  .fifo_lvl   (fifo_lvl),
  .int_state  (int_state),
  .shift_busy (shift_busy),
  .txd        (txd),
  .tx_en      (tx_en),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .rsp_valid  (rsp_valid)
);

// File: tb/test_sertx_top.sv
module test_sertx_top;
  localparam logic [9:0] A_ISTATE = 10'h000;
  localparam logic [9:0] A_IEN    = 10'h004;
  localparam logic [9:0] A_ITEST  = 10'h008;
  localparam logic [9:0] A_CTRL   = 10'h00C;
  localparam logic [9:0] A_STAT   = 10'h010;
  localparam logic [9:0] A_RXD    = 10'h014;
  localparam logic [9:0] A_TXD    = 10'h018;
  localparam logic [9:0] A_FCTRL  = 10'h01C;
  localparam logic [9:0] A_FSTAT  = 10'h020;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        txd;
  logic        irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  sertx_top #(.DEPTH(DEPTH)) i_sertx_top (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .txd(txd), .irq_tx_wm(irq_tx_wm), .irq_rx_wm(irq_rx_wm),
    .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic br(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    if (rsp_valid !== 1'b1) begin
      total++; bad++;
      $display("FAIL R11 actual=%b expected=1 (rsp_valid)", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    br(a, v);
    chk(req, v, exp);
  endtask

  task automatic get_frame(input int per, output logic [7:0] b, output logic good);
    int waitc = 0;
    good = 1'b1;
    b = '0;
    while (txd !== 1'b0 && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    if (waitc >= 5000) good = 1'b0;
    repeat (per / 2) @(negedge clk);
    if (txd !== 1'b0) good = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (per) @(negedge clk);
      b[i] = txd;
    end
    repeat (per) @(negedge clk);
    if (txd !== 1'b1) good = 1'b0;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  bytes [6];
    logic [7:0]  got;
    logic        good;
    int          stuck;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    chk("R3 txd", {31'b0, txd}, 32'h1);
    chk("R3 irqs", {28'b0, irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm}, 32'h0);
    chk("R3 rx_ready", {31'b0, rx_ready}, 32'h0);
    rd_chk("R3 istate", A_ISTATE, 32'h0);
    rd_chk("R3 ien", A_IEN, 32'h0);
    rd_chk("R3 ctrl", A_CTRL, 32'h0);
    rd_chk("R3 status", A_STAT, 32'h3C);
    rd_chk("R3 rxdata", A_RXD, 32'h0);
    rd_chk("R3 fctrl", A_FCTRL, 32'h0);
    rd_chk("R3 fstat", A_FSTAT, 32'h0);

    // R11: write-only, unmapped and misaligned accesses
    rd_chk("R11 itest reads 0", A_ITEST, 32'h0);
    rd_chk("R11 txdata reads 0", A_TXD, 32'h0);
    rd_chk("R11 fstat untouched by txdata read", A_FSTAT, 32'h0);
    rd_chk("R11 unmapped", 10'h3FC, 32'h0);
    bw(A_IEN | 10'h1, 32'hF);
    rd_chk("R11 misaligned write ignored", A_IEN, 32'h0);
    bw(A_IEN, 32'h5);
    rd_chk("R11 misaligned read", A_IEN | 10'h2, 32'h0);

    // R2: test register ORs in
    bw(A_ITEST, 32'h1);
    bw(A_ITEST, 32'h2);
    rd_chk("R2 test ORs", A_ISTATE, 32'h3);
    bw(A_ISTATE, 32'hF);

    // R1 / R2 sweep over all state and enable patterns
    for (int s = 0; s < 16; s++) begin
      bw(A_ISTATE, 32'hF);
      bw(A_ITEST, s);
      rd_chk("R2 test sets", A_ISTATE, s);
      for (int e = 0; e < 16; e++) begin
        bw(A_IEN, e);
        chk("R1 irq gating", {28'b0, irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm},
            32'(s & e));
      end
      bw(A_ISTATE, 32'h5);
      rd_chk("R2 w1c partial", A_ISTATE, 32'(s & 4'hA));
      bw(A_ISTATE, 32'hF);
      rd_chk("R2 w1c all", A_ISTATE, 32'h0);
    end

    // R4 / R5 sweep: every threshold, fill with TX disabled
    for (int t = 0; t < DEPTH; t++) begin
      bw(A_FCTRL, (t << 8) | 32'h2);
      bw(A_ISTATE, 32'hF);
      for (int k = 1; k <= DEPTH; k++) begin
        bw(A_TXD, k);
        br(A_ISTATE, v);
        chk("R5 watermark on push", {31'b0, v[0]}, (k >= t) ? 32'h1 : 32'h0);
        rd_chk("R4 level", A_FSTAT, k);
      end
      br(A_STAT, v);
      chk("R4 tx full flag", {31'b0, v[0]}, 32'h1);
      bw(A_TXD, 32'hEE);
      rd_chk("R4 push into full dropped", A_FSTAT, DEPTH);
    end

    // R7: FIFO reset
    bw(A_FCTRL, 32'h2);
    rd_chk("R7 level after flush", A_FSTAT, 32'h0);
    rd_chk("R7 status after flush", A_STAT, 32'h3C);
    bw(A_CTRL, 32'h4000_0001);
    stuck = 0;
    repeat (80) begin
      @(negedge clk);
      if (txd !== 1'b1) stuck++;
    end
    chk("R7 flushed bytes not sent", stuck, 0);
    bw(A_CTRL, 32'h4000_0000);

    // R9, R5, R6, R8: load six bytes while disabled, then drain
    bw(A_FCTRL, (4 << 8) | 32'h2);
    bw(A_ISTATE, 32'hF);
    for (int i = 0; i < 6; i++) begin
      bytes[i] = 8'(8'h3C ^ (i * 37) ^ (i << 6));
      bw(A_TXD, bytes[i]);
    end
    rd_chk("R5 watermark reached", A_ISTATE, 32'h1);
    stuck = 0;
    repeat (60) begin
      @(negedge clk);
      if (txd !== 1'b1) stuck++;
    end
    chk("R9 txd held while disabled", stuck, 0);
    rd_chk("R9 level held while disabled", A_FSTAT, 32'h6);
    bw(A_CTRL, 32'h4000_0001);
    for (int i = 0; i < 6; i++) begin
      get_frame(4, got, good);
      chk("R8 frame shape", {31'b0, good}, 32'h1);
      chk("R8 frame data", got, bytes[i]);
    end
    repeat (30) @(negedge clk);
    rd_chk("R6 empty set, watermark cleared", A_ISTATE, 32'h4);
    rd_chk("R6 status empty and idle", A_STAT, 32'h3C);
    bw(A_IEN, 32'hF);
    chk("R1 irq after drain", {28'b0, irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm}, 32'h4);

    // R12: slower baud increment
    bw(A_CTRL, 32'h2000_0001);
    bw(A_TXD, 32'hA5);
    get_frame(8, got, good);
    chk("R12 frame shape at 8 clocks/bit", {31'b0, good}, 32'h1);
    chk("R12 frame data at 8 clocks/bit", got, 32'hA5);
    bw(A_TXD, 32'h81);
    get_frame(8, got, good);
    chk("R12 second frame", got, 32'h81);

    // R10: receive holding register
    repeat (20) @(negedge clk);
    chk("R10 rx_ready off", {31'b0, rx_ready}, 32'h0);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A;
    @(negedge clk); rx_valid = 1'b0;
    rd_chk("R10 byte ignored while disabled", A_STAT, 32'h3C);
    rd_chk("R10 rxdata unchanged", A_RXD, 32'h0);
    bw(A_CTRL, 32'h2000_0003);
    chk("R10 rx_ready on", {31'b0, rx_ready}, 32'h1);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hC3;
    @(negedge clk); rx_valid = 1'b0;
    rd_chk("R10 flags after arrival", A_STAT, 32'h0E);
    rd_chk("R10 rxdata value", A_RXD, 32'hC3);
    rd_chk("R10 flags after read", A_STAT, 32'h3C);

    finish_run();
  end
endmodule